// File: doc/BRIEF.md
# Non-Restoring Division Step Unit

This block carries out one iteration of a bit-serial non-restoring divider on W-bit (32 by default) operands. Each strobe takes a partial remainder, a divisor, the running quotient-sign bit, the divisor-sign bit and a carry-in bit. The carry-in is shifted into the bottom of the remainder. The unit then adds the divisor to the result or subtracts it, and returns the new remainder, the new quotient-sign bit and one quotient bit.

Controlling logic issues thirty-two such steps to divide fully. Between steps it rotates the dividend through the quotient bit, so quotient bits are collected in the dividend register. Three jobs sit outside this unit: preparing the sign bits before the first step, sequencing the steps, and rotating the quotient. The step itself is combinational. Its results are captured in output registers on the step strobe and held while the strobe is low.

Top module: `nr_div_step`

## Requirements
- R1: After a synchronous active-low reset, `rem_out`, `q_out` and `t_out` are all 0.
- R2: The working value is `{rem_in[W-2:0], t_in}`, and `rem_in[W-1]` is the shifted-out bit.
- R3: When `q_in == m_in`, `rem_out` becomes the working value minus `dvsr_in`, modulo 2^W.
- R4: When `q_in != m_in`, `rem_out` becomes the working value plus `dvsr_in`, modulo 2^W.
- R5: On a subtraction, the borrow is 1 when the unsigned working value is less than `dvsr_in`. With `m_in = 0`, the new Q is shifted-out XOR borrow. With `m_in = 1`, it is the inverse of that.
- R6: On an addition, the carry is bit W of the unsigned sum. With `m_in = 0` (so `q_in = 1`), the new Q is shifted-out XOR carry. With `m_in = 1`, it is the inverse of that.
- R7: `t_out` is 1 exactly when the new `q_out` equals the `m_in` of that step.
- R8: While `step_en` is 0, `rem_out`, `q_out` and `t_out` keep their values, whatever the other inputs do.
- R9: The outputs change on the first rising clock edge at which `step_en` is 1, with no further latency.
- R10: Start from remainder 0, divisor d != 0, Q = M = T = 0 and dividend a. Each round rotates the dividend left through T and then takes one step. After 32 rounds, one final rotate leaves floor(a / d) in the dividend.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Capture one step's result |
| rem_in | input | W | Partial remainder before the step |
| dvsr_in | input | W | Divisor |
| q_in | input | 1 | Quotient-sign bit before the step |
| m_in | input | 1 | Divisor-sign bit |
| t_in | input | 1 | Bit shifted into the remainder |
| rem_out | output | W | Partial remainder after the step |
| q_out | output | 1 | Quotient-sign bit after the step |
| t_out | output | 1 | Quotient bit produced by the step |

## Verification
The assertions check four things on every strobe, against values recomputed from the sampled inputs: the choice between add and subtract, the remainder arithmetic, the new Q from the shifted-out bit and the carry or borrow, and the relation between T and M. On every idle cycle they check that the outputs hold. Only the bench scenarios can show two things: the reset values, and that thirty-two chained steps with rotation really produce the unsigned quotient. The assertions see only a single step, while the division property lives in the sequence.

// File: rtl/divstep_pkg.sv
// Package: shared width default and the operation encoding for the division step.
// Assumes: nothing beyond a W-bit datapath with W >= 2.
package divstep_pkg;
    localparam int DATA_W = 32;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;
endpackage

// File: rtl/divstep_shift.sv
// Module: left shift of the partial remainder with the carry-in bit placed at bit 0.
// Assumes: W >= 2; purely combinational.
module divstep_shift #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem,
    input  logic         cin,
    output logic [W-1:0] shifted,
    output logic         shout
);
    // Build the working value and expose the dropped top bit.
    always_comb begin
        shifted = {rem[W-2:0], cin};
        shout   = rem[W-1];
    end
endmodule

// File: rtl/divstep_addsub.sv
// Module: W-bit adder/subtractor returning the carry (add) or borrow (subtract).
// Assumes: unsigned operands; the flag is bit W of a W+1 bit operation.
module divstep_addsub
    import divstep_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_e          op,
    output logic [W-1:0] res,
    output logic         cy
);
    localparam int XW = W + 1;

    logic [XW-1:0] ext;

    // One extended-width operation; the top bit is the carry or borrow.
    always_comb begin
        if (op == OP_SUB) begin
            ext = {1'b0, a} - {1'b0, b};
        end else begin
            ext = {1'b0, a} + {1'b0, b};
        end
        res = ext[W-1:0];
        cy  = ext[XW-1];
    end
endmodule

// File: rtl/divstep_qlogic.sv
// Module: new quotient-sign bit and quotient bit from the step's flags.
// Assumes: cy is a borrow on subtraction (q_old == m) and a carry on addition.
module divstep_qlogic (
    input  logic shout,
    input  logic cy,
    input  logic q_old,
    input  logic m,
    output logic q_new,
    output logic t_new
);
    // Table over (old Q, M), each entry picking the flag or its inverse.
    always_comb begin
        unique case ({q_old, m})
            2'b00:   q_new = shout ? ~cy : cy;
            2'b01:   q_new = shout ? cy  : ~cy;
            2'b10:   q_new = shout ? ~cy : cy;
            default: q_new = shout ? cy  : ~cy;
        endcase
        t_new = (q_new == m);
    end
endmodule

// File: rtl/nr_div_step.sv
// Module: one non-restoring division step with registered results.
// Assumes: the caller prepares Q, M and T and rotates the quotient between
// steps; results are captured only on step_en and held otherwise.
module nr_div_step
    import divstep_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] dvsr_in,
    input  logic         q_in,
    input  logic         m_in,
    input  logic         t_in,
    output logic [W-1:0] rem_out,
    output logic         q_out,
    output logic         t_out
);
    logic [W-1:0] shifted;
    logic         shout;
    op_e          op;
    logic [W-1:0] sum;
    logic         cy;
    logic         q_nxt;
    logic         t_nxt;

    divstep_shift #(.W(W)) u_shift (
        .rem     (rem_in),
        .cin     (t_in),
        .shifted (shifted),
        .shout   (shout)
    );

    // Subtract when the old Q matches M, otherwise add.
    always_comb begin
        op = (q_in == m_in) ? OP_SUB : OP_ADD;
    end

    divstep_addsub #(.W(W)) u_addsub (
        .a   (shifted),
        .b   (dvsr_in),
        .op  (op),
        .res (sum),
        .cy  (cy)
    );

    divstep_qlogic u_qlogic (
        .shout (shout),
        .cy    (cy),
        .q_old (q_in),
        .m     (m_in),
        .q_new (q_nxt),
        .t_new (t_nxt)
    );

    // Result registers: clear on reset, load on strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_out <= '0;
            q_out   <= 1'b0;
            t_out   <= 1'b0;
        end else if (step_en) begin
            rem_out <= sum;
            q_out   <= q_nxt;
            t_out   <= t_nxt;
        end
    end
endmodule

// File: rtl/nr_div_step_chk.sv
// Checker: per-step properties of nr_div_step, recomputed from sampled ports.
// Assumes: attached by the bind at the end of this file.
module nr_div_step_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         step_en,
    input logic [W-1:0] rem_in,
    input logic [W-1:0] dvsr_in,
    input logic         q_in,
    input logic         m_in,
    input logic         t_in,
    input logic [W-1:0] rem_out,
    input logic         q_out,
    input logic         t_out
);
    logic [W-1:0] work;
    logic [W:0]   wide_sum;
    logic         flag;

    // Independent reference for the working value and the carry/borrow.
    always_comb begin
        work     = {rem_in[W-2:0], t_in};
        wide_sum = {1'b0, work} + {1'b0, dvsr_in};
        flag     = (q_in == m_in) ? (work < dvsr_in) : wide_sum[W];
    end

    AST_SUB_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && q_in == m_in) |=> rem_out == $past(work) - $past(dvsr_in)); // R3
    AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && q_in != m_in) |=> rem_out == $past(work) + $past(dvsr_in)); // R4
    AST_NEW_Q: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> q_out == ($past(rem_in[W-1]) ^ $past(flag) ^ $past(m_in))); // R5
    AST_T_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> t_out == (q_out == $past(m_in))); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> ($stable(rem_out) && $stable(q_out) && $stable(t_out))); // R8
endmodule

bind nr_div_step nr_div_step_chk #(.W(W)) u_chk (.*);

// File: tb/nr_div_step_bench.sv
// Bench: directed scenarios for nr_div_step, one task each, with a reference model.
module nr_div_step_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         step_en = 1'b0;
    logic [W-1:0] rem_in = '0;
    logic [W-1:0] dvsr_in = '0;
    logic         q_in = 1'b0;
    logic         m_in = 1'b0;
    logic         t_in = 1'b0;
    logic [W-1:0] rem_out;
    logic         q_out;
    logic         t_out;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    nr_div_step #(.W(W)) u_nr_div_step (
        .clk(clk), .rst_n(rst_n), .step_en(step_en),
        .rem_in(rem_in), .dvsr_in(dvsr_in),
        .q_in(q_in), .m_in(m_in), .t_in(t_in),
        .rem_out(rem_out), .q_out(q_out), .t_out(t_out)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference step built from the requirement text.
    task automatic ref_step(input logic [W-1:0] r, input logic [W-1:0] d, input logic q,
                            input logic m, input logic t, output logic [W-1:0] ro,
                            output logic qo, output logic to);
        logic [W-1:0] wv = {r[W-2:0], t};
        logic [W:0]   s;
        logic         f;
        if (q == m) begin
            s = {1'b0, wv} - {1'b0, d};
            f = (wv < d);
        end else begin
            s = {1'b0, wv} + {1'b0, d};
            f = s[W];
        end
        ro = s[W-1:0];
        qo = m ? ~(r[W-1] ^ f) : (r[W-1] ^ f);
        to = (qo == m);
    endtask

    // Drive one strobed step at a falling edge; sample at the next falling edge.
    task automatic do_step(input logic [W-1:0] r, input logic [W-1:0] d,
                           input logic q, input logic m, input logic t);
        @(negedge clk);
        rem_in = r; dvsr_in = d; q_in = q; m_in = m; t_in = t; step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
    endtask

    task automatic test_reset();
        check(rem_out == '0, "R1 rem", rem_out, 0);
        check(q_out == 1'b0, "R1 q", q_out, 0);
        check(t_out == 1'b0, "R1 t", t_out, 0);
    endtask

    task automatic test_quadrants();
        logic [W-1:0] er;
        logic eq, et;
        logic [W-1:0] rs [4] = '{32'h0000_1234, 32'h8000_0010, 32'h7FFF_FFFF, 32'hC000_0000};
        logic [W-1:0] ds [4] = '{32'h0000_3000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h4000_0001};
        for (int qm = 0; qm < 4; qm++) begin
            for (int k = 0; k < 4; k++) begin
                for (int t = 0; t < 2; t++) begin
                    ref_step(rs[k], ds[k], qm[1], qm[0], t[0], er, eq, et);
                    do_step(rs[k], ds[k], qm[1], qm[0], t[0]);
                    // R2 R3 R4 remainder, R9 seen one edge after the strobe
                    check(rem_out == er, (qm[1] == qm[0]) ? "R3 R2 R9 rem" : "R4 R2 R9 rem",
                          rem_out, er);
                    check(q_out == eq, (qm[1] == qm[0]) ? "R5 q" : "R6 q", q_out, eq);
                    check(t_out == et, "R7 t", t_out, et);
                end
            end
        end
    endtask

    task automatic test_hold();
        logic [W-1:0] r0;
        logic q0, t0;
        do_step(32'h8765_4321, 32'h0000_0F0F, 1'b1, 1'b0, 1'b1);
        r0 = rem_out; q0 = q_out; t0 = t_out;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rem_in = $urandom; dvsr_in = $urandom; q_in = ~q_in; m_in = ~m_in; t_in = ~t_in;
        end
        @(negedge clk);
        check(rem_out == r0, "R8 rem", rem_out, r0);
        check(q_out == q0, "R8 q", q_out, q0);
        check(t_out == t0, "R8 t", t_out, t0);
    endtask

    task automatic run_divide(input logic [W-1:0] a, input logic [W-1:0] d);
        logic [W-1:0] dvd = a;
        logic [W-1:0] r = '0;
        logic q = 1'b0, t = 1'b0, top;
        for (int i = 0; i < W; i++) begin
            top = dvd[W-1];
            dvd = {dvd[W-2:0], t};
            t = top;
            do_step(r, d, q, 1'b0, t);
            r = rem_out; q = q_out; t = t_out;
        end
        dvd = {dvd[W-2:0], t};
        check(dvd == a / d, "R10 quotient", dvd, a / d);
    endtask

    task automatic test_divide();
        run_divide(32'd100, 32'd7);
        run_divide(32'hFFFF_FFFF, 32'd1);
        run_divide(32'd5, 32'd10);
        run_divide(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_divide(32'h8000_0000, 32'h0000_0003);
        for (int i = 0; i < 10; i++) begin
            logic [W-1:0] a = $urandom;
            logic [W-1:0] d = ($urandom >> (i * 3)) | 32'd1;
            run_divide(a, d);
        end
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_quadrants();
        test_hold();
        test_divide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule